// File: doc/BRIEF.md
# Fractional-N Division Ratio Sequencer

This block supplies the feedback divider of a fractional-N synthesizer with a fresh integer division ratio on every reference cycle. Each time the reference strobe arrives it advances a third-order noise-shaping modulator. The modulator is built from three cascaded accumulators that wrap at a programmable modulus, which does not have to be a power of two. Their carries are merged into a small signed offset, and the block registers integer part plus offset as the next ratio. Over time the ratios average to integer + fraction / modulus. The loop sees a sequence whose quantisation error has been pushed to high offset frequencies.

An optional dither input adds a pseudo-random least significant bit to the first accumulator input. It is meant for the lowest-spur configuration and is held off in the low-noise configurations. A phase-resync timer lets software make the output phase repeatable after a channel change. Each channel load with a nonzero resync multiplier arms a delay of delay × multiplier reference cycles. At the end of that delay the modulator history is cleared. The timer is a two-state machine:
- RS_IDLE goes to RS_WAIT on an arming load.
- RS_WAIT stays in RS_WAIT on a re-arming load. This is the restart transition.
- RS_WAIT goes back to RS_IDLE on a load with multiplier 0. This is the cancel transition.
- RS_WAIT goes back to RS_IDLE on the reference tick that ends the delay. This is the fire transition.

The integer part must stay at or above the prescaler floor of the surrounding divider: 31 with a 4/5 prescaler and 91 with an 8/9 prescaler. The modulus must be held constant while the accumulators hold data.

Top module: `frac_sdm_ctrl`

## Requirements
- R1: With dither off and starting from cleared state, the sum of div_n over any whole number of modulus periods differs from periods × (MOD × INT + FRAC) by at most 2.
- R2: On a reference tick that is not a resync fire, div_n becomes INT + c1 + (c2 − c2') + (c3 − 2·c3' + c3''). Here ck is the carry of stage k in this tick and a prime marks the same carry one or two ticks earlier. Stage 1 adds FRAC (plus dither), stage 2 adds the new stage-1 residue, and stage 3 adds the new stage-2 residue.
- R3: Each accumulator keeps its residue in 0..MOD−1. It carries and subtracts MOD when its sum reaches MOD. FRAC = MOD from cleared state gives INT+1 on every tick.
- R4: After every reference tick, div_n − INT lies in −3..+4.
- R5: div_n changes only on a cycle with ref_tick high.
- R6: FRAC = 0 from cleared state gives div_n = INT on every tick.
- R7: With dither_en high, the stage-1 addend is FRAC + bit 0 of a 16-bit LFSR when FRAC < MOD, and FRAC alone otherwise. The LFSR is seeded with 0xACE1 and shifts left on every tick while dither_en is high. The new bit 0 is bit15 ^ bit13 ^ bit12 ^ bit10. With dither_en low the LFSR holds.
- R8: A chan_load with resync_mul ≠ 0 loads resync_dly × resync_mul (0 is treated as 1). The count runs on ticks after the load cycle. The tick that completes it clears all residues and carry history, reseeds the LFSR and sets div_n to INT.
- R9: A chan_load with resync_mul = 0 arms nothing and cancels a pending resync.
- R10: A chan_load while a resync is pending restarts the count from the new product.
- R11: After reset div_n is 0 and all modulator state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ref_tick | input | 1 | One-cycle strobe per reference cycle |
| chan_load | input | 1 | Strobe marking a write of a new channel word |
| int_val | input | 9 | Integer part of the ratio |
| frac_val | input | 12 | Fraction numerator, 0..MOD |
| mod_val | input | 12 | Modulus, 2..4095 |
| dither_en | input | 1 | Enables LSB dither on stage 1 |
| resync_mul | input | 12 | Resync multiplier, 0 disables resync |
| resync_dly | input | 4 | Resync delay count |
| div_n | output | 10 | Registered division ratio |

## Verification
The hardest situations to reach from the ports are the resync timer's edge cases. One is a re-arming load arriving part way through a count. Another is a cancelling load while a resync is pending. A third is a zero delay that has to fire on the very next tick. The stimulus first drives the modulator into a nonzero state. It then issues loads interleaved with sparse ticks, so that each fire lands on a tick where the cleared output visibly differs from the free-running sequence. A wide-modulus run with dither is included so that the LFSR and all three carries are active at once.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
    typedef enum logic [0:0] {
        RS_IDLE = 1'b0,
        RS_WAIT = 1'b1
    } rs_state_e;

    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/sdm_mod_acc.sv
module sdm_mod_acc #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         clear,
    input  logic [W-1:0] modulus,
    input  logic [W-1:0] addend,
    output logic         carry,
    output logic [W-1:0] next_res,
    output logic [W-1:0] res
);
    logic [W:0] sum;

    always_comb begin
        sum      = {1'b0, res} + {1'b0, addend};
        carry    = (sum >= {1'b0, modulus});
        next_res = carry ? W'(sum - {1'b0, modulus}) : sum[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     res <= '0;
        else if (clear) res <= '0;
        else if (step)  res <= next_res;
    end

    // R3: a legal step keeps the residue below the modulus
    p_residue_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && (res < modulus) && (addend <= modulus))
        |=> (res < $past(modulus)));
endmodule

// File: rtl/sdm_dither_lfsr.sv
module sdm_dither_lfsr
    import sdm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic reseed,
    output logic bit_o
);
    logic [LFSR_W-1:0] lfsr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lfsr <= LFSR_SEED;
        else if (reseed)  lfsr <= LFSR_SEED;
        else if (advance) lfsr <= {lfsr[LFSR_W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    assign bit_o = lfsr[0];

    // R7: the generator never locks up in the all-zero state
    p_lfsr_alive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0);
endmodule

// File: rtl/sdm_resync_fsm.sv
module sdm_resync_fsm
    import sdm_pkg::*;
#(
    parameter int MUL_W = 12,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic [MUL_W-1:0] mul,
    input  logic [DLY_W-1:0] dly,
    output logic             clear_o
);
    localparam int CNT_W = MUL_W + DLY_W;

    rs_state_e        state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [CNT_W-1:0] product;

    assign product = CNT_W'(dly) * CNT_W'(mul);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RS_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        clear_o  = 1'b0;
        if (load) begin
            if (mul != '0) begin
                state_nx = RS_WAIT;
                cnt_nx   = product;
            end else begin
                state_nx = RS_IDLE;
            end
        end else begin
            unique case (state)
                RS_IDLE: ;
                RS_WAIT: begin
                    if (tick) begin
                        if (cnt <= CNT_W'(1)) begin
                            clear_o  = 1'b1;
                            state_nx = RS_IDLE;
                        end else begin
                            cnt_nx = cnt - CNT_W'(1);
                        end
                    end
                end
                default: state_nx = RS_IDLE;
            endcase
        end
    end

    // R8: a fire only ever happens on a reference tick
    p_fire_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |-> (tick && !load));
    // R9: multiplier zero leaves the timer idle
    p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && mul == '0) |=> (state == RS_IDLE));
    // R10: any arming load leaves the timer waiting
    p_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load && mul != '0) |=> (state == RS_WAIT));
endmodule

// File: rtl/frac_sdm_ctrl.sv
module frac_sdm_ctrl #(
    parameter int INT_W = 9,
    parameter int MOD_W = 12,
    parameter int MUL_W = 12,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             chan_load,
    input  logic [INT_W-1:0] int_val,
    input  logic [MOD_W-1:0] frac_val,
    input  logic [MOD_W-1:0] mod_val,
    input  logic             dither_en,
    input  logic [MUL_W-1:0] resync_mul,
    input  logic [DLY_W-1:0] resync_dly,
    output logic [INT_W:0]   div_n
);
    localparam int STAGES = 3;
    localparam int OUT_W  = INT_W + 1;

    logic             resync_clr;
    logic             dith_bit;
    logic [MOD_W-1:0] addend [STAGES];
    logic [MOD_W-1:0] nres   [STAGES];
    logic [MOD_W-1:0] res    [STAGES];
    logic             cy     [STAGES];
    logic             h2, h3a, h3b;
    logic signed [3:0] offs;

    sdm_resync_fsm #(.MUL_W(MUL_W), .DLY_W(DLY_W)) u_resync (
        .clk(clk), .rst_n(rst_n), .load(chan_load), .tick(ref_tick),
        .mul(resync_mul), .dly(resync_dly), .clear_o(resync_clr)
    );

    sdm_dither_lfsr u_dither (
        .clk(clk), .rst_n(rst_n), .advance(ref_tick && dither_en),
        .reseed(resync_clr), .bit_o(dith_bit)
    );

    assign addend[0] = frac_val + MOD_W'((dither_en && (frac_val < mod_val)) ? dith_bit : 1'b0);

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k > 0) begin : g_chain
            assign addend[k] = nres[k-1];
        end
        sdm_mod_acc #(.W(MOD_W)) u_acc (
            .clk(clk), .rst_n(rst_n), .step(ref_tick), .clear(resync_clr),
            .modulus(mod_val), .addend(addend[k]),
            .carry(cy[k]), .next_res(nres[k]), .res(res[k])
        );
    end

    always_comb begin
        offs = $signed({3'b000, cy[0]})
             + $signed({3'b000, cy[1]}) - $signed({3'b000, h2})
             + $signed({3'b000, cy[2]}) - $signed({2'b00, h3a, 1'b0})
             + $signed({3'b000, h3b});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_n <= '0;
            h2    <= 1'b0;
            h3a   <= 1'b0;
            h3b   <= 1'b0;
        end else if (resync_clr) begin
            div_n <= {1'b0, int_val};
            h2    <= 1'b0;
            h3a   <= 1'b0;
            h3b   <= 1'b0;
        end else if (ref_tick) begin
            div_n <= {1'b0, int_val} + {{(OUT_W-4){offs[3]}}, offs};
            h2    <= cy[1];
            h3a   <= cy[2];
            h3b   <= h3a;
        end
    end

    // R4: every ratio stays within the MASH offset window
    p_offset_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ref_tick) |->
            (($signed({1'b0, div_n}) - $signed({2'b00, $past(int_val)}) >= -3) &&
             ($signed({1'b0, div_n}) - $signed({2'b00, $past(int_val)}) <= 4)));
    // R5: no tick, no change
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick |=> $stable(div_n));
    // R8: a fire lands the ratio exactly on the integer part
    p_fire_int_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resync_clr |=> (div_n == {1'b0, $past(int_val)}));
endmodule

// File: tb/tb_frac_sdm_ctrl.sv
module tb_frac_sdm_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        chan_load = 1'b0;
    logic [8:0]  int_val = 9'd40;
    logic [11:0] frac_val = 12'd0;
    logic [11:0] mod_val = 12'd7;
    logic        dither_en = 1'b0;
    logic [11:0] resync_mul = 12'd0;
    logic [3:0]  resync_dly = 4'd0;
    logic [9:0]  div_n;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // behavioural model state
    int a1, a2, a3, p2, p3a, p3b, lf, expv, pend, cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_sdm_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .chan_load(chan_load),
        .int_val(int_val), .frac_val(frac_val), .mod_val(mod_val),
        .dither_en(dither_en), .resync_mul(resync_mul), .resync_dly(resync_dly),
        .div_n(div_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic void model_clear();
        a1 = 0; a2 = 0; a3 = 0; p2 = 0; p3a = 0; p3b = 0; lf = 16'hACE1;
    endfunction

    function automatic void model_step(input bit tk, input bit ld);
        int m, x, c1, c2, c3, d, fb;
        bit fire;
        m = int'(mod_val);
        fire = 0;
        if (ld) begin
            if (resync_mul != 0) begin
                pend = 1;
                cnt = int'(resync_dly) * int'(resync_mul);
            end else pend = 0;
        end else if (tk && pend != 0) begin
            if (cnt <= 1) begin fire = 1; pend = 0; end
            else cnt = cnt - 1;
        end
        if (fire) begin
            model_clear();
            expv = int'(int_val);
        end else if (tk) begin
            d = (dither_en && frac_val < mod_val) ? (lf & 1) : 0;
            if (dither_en) begin
                fb = ((lf >> 15) ^ (lf >> 13) ^ (lf >> 12) ^ (lf >> 10)) & 1;
                lf = ((lf << 1) | fb) & 16'hFFFF;
            end
            x = a1 + int'(frac_val) + d; c1 = (x >= m); a1 = c1 ? x - m : x;
            x = a2 + a1;                 c2 = (x >= m); a2 = c2 ? x - m : x;
            x = a3 + a2;                 c3 = (x >= m); a3 = c3 ? x - m : x;
            expv = int'(int_val) + c1 + c2 - p2 + c3 - 2 * p3a + p3b;
            p2 = c2; p3b = p3a; p3a = c3;
        end
    endfunction

    // one clock: drive at negedge, model the edge, compare at next negedge
    task automatic cyc(input bit tk, input bit ld, input string tag);
        int off;
        ref_tick = tk;
        chan_load = ld;
        model_step(tk, ld);
        @(posedge clk);
        @(negedge clk);
        ref_tick = 0;
        chan_load = 0;
        chk(int'(div_n) == expv, tag, int'(div_n), expv);
        if (tk) begin
            off = int'(div_n) - int'(int_val);
            chk(off >= -3 && off <= 4, "R4 offset window", off, 0);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        ref_tick = 0;
        chan_load = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_clear();
        expv = 0; pend = 0; cnt = 0;
        chk(div_n == 0, "R11 reset value", int'(div_n), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int sum;
        @(negedge clk);
        do_reset();

        // R6: zero fraction from cleared state
        int_val = 9'd40; frac_val = 12'd0; mod_val = 12'd7;
        for (int i = 0; i < 20; i++) begin
            cyc(1, 0, "R6 model");
            chk(div_n == 10'd40, "R6 constant INT", int'(div_n), 40);
        end

        // R3: fraction equal to modulus
        frac_val = 12'd7;
        for (int i = 0; i < 20; i++) begin
            cyc(1, 0, "R3 model");
            chk(div_n == 10'd41, "R3 FRAC=MOD gives INT+1", int'(div_n), 41);
        end

        // R2 / R1: non-power-of-two modulus
        do_reset();
        int_val = 9'd100; frac_val = 12'd3; mod_val = 12'd13;
        sum = 0;
        for (int i = 0; i < 260; i++) begin
            cyc(1, 0, "R2 recurrence");
            sum += int'(div_n);
        end
        chk((sum - 26060) >= -2 && (sum - 26060) <= 2, "R1 average", sum, 26060);

        // R5: sparse ticks, output must hold between them
        frac_val = 12'd5;
        for (int i = 0; i < 60; i++) cyc((i % 3) == 0, 0, "R5 hold between ticks");

        // R7: dither on a wide modulus, then the FRAC=MOD boundary, then off
        do_reset();
        int_val = 9'd200; frac_val = 12'd1234; mod_val = 12'd4000; dither_en = 1;
        for (int i = 0; i < 300; i++) cyc(1, 0, "R7 dither");
        frac_val = 12'd4000;
        for (int i = 0; i < 20; i++) cyc(1, 0, "R7 dither suppressed at FRAC=MOD");
        dither_en = 0; frac_val = 12'd777;
        for (int i = 0; i < 40; i++) cyc(i % 2 == 0, 0, "R7 dither off");

        // R8: resync after 2 x 3 ticks
        do_reset();
        int_val = 9'd60; frac_val = 12'd5; mod_val = 12'd11;
        for (int i = 0; i < 10; i++) cyc(1, 0, "R8 warm-up");
        resync_mul = 12'd3; resync_dly = 4'd2;
        cyc(0, 1, "R8 arm");
        for (int i = 0; i < 5; i++) cyc(1, 0, "R8 counting");
        cyc(1, 0, "R8 fire");
        chk(div_n == 10'd60, "R8 fire gives INT", int'(div_n), 60);
        for (int i = 0; i < 15; i++) cyc(1, 0, "R8 after fire");

        // R10: restart mid-count
        resync_mul = 12'd2; resync_dly = 4'd3;
        cyc(1, 1, "R10 arm with tick");
        for (int i = 0; i < 3; i++) cyc(1, 0, "R10 partial count");
        resync_mul = 12'd1; resync_dly = 4'd4;
        cyc(0, 1, "R10 rearm");
        for (int i = 0; i < 3; i++) cyc(1, 0, "R10 counting again");
        cyc(1, 0, "R10 fire");
        chk(div_n == 10'd60, "R10 fire after restart", int'(div_n), 60);
        for (int i = 0; i < 8; i++) cyc(1, 0, "R10 after fire");

        // R9: cancel a pending resync with multiplier zero
        resync_mul = 12'd2; resync_dly = 4'd2;
        cyc(0, 1, "R9 arm");
        cyc(1, 0, "R9 one tick");
        resync_mul = 12'd0;
        cyc(0, 1, "R9 cancel");
        for (int i = 0; i < 20; i++) cyc(1, 0, "R9 no fire after cancel");

        // R8: zero delay fires on the first tick
        resync_mul = 12'd5; resync_dly = 4'd0;
        cyc(0, 1, "R8 zero delay arm");
        cyc(1, 0, "R8 zero delay fire");
        chk(div_n == 10'd60, "R8 zero delay gives INT", int'(div_n), 60);
        for (int i = 0; i < 6; i++) cyc(1, 0, "R8 zero delay after");

        // R4: top of the integer range with a near-full fraction
        do_reset();
        resync_mul = 12'd0;
        int_val = 9'd511; frac_val = 12'd4094; mod_val = 12'd4095;
        for (int i = 0; i < 200; i++) cyc(1, 0, "R4 wide range");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule